// File: doc/BRIEF.md
# Multi-Scheme Branch Direction Predictor Table

This block is a direct-mapped table of per-branch history that a fetch unit consults to guess whether a conditional branch will be taken. A fetch address is presented on the lookup side, and the taken/not-taken guess comes back in the same cycle. When the branch later resolves, its address and real outcome are written back on the update side. The block then revises that branch's history entry.

A two-bit mode input chooses how every entry's history is read and advanced. The first scheme repeats the last outcome. The second is a four-state saturating counter. The third keeps the last three outcomes and predicts by majority vote. All three schemes share the same storage of three history bits per entry. The mode is meant to be chosen while reset is held. The table has 128 sets of 4 entries, so it holds 512 entries. Target addresses and tags are not part of this block: two branches that map to the same entry share its history.

Top module: `bht_multi`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) initialises every entry. It loads 3'b001 (weakly not taken) when mode is 01 or 11, and 3'b000 when mode is 00 or 10. Right after reset, every lookup predicts not taken in every mode.
- R2: The mode encoding is 00 = last-outcome scheme, 01 = two-bit counter scheme, 10 = three-outcome majority scheme. Mode 11 behaves exactly like 01.
- R3: In the last-outcome scheme, a lookup predicts the outcome of the most recent update to that entry.
- R4: In the two-bit scheme, the low two history bits hold 11 = strongly taken, 10 = weakly taken, 01 = weakly not taken, 00 = strongly not taken. States 11 and 10 predict taken; states 01 and 00 predict not taken.
- R5: In the two-bit scheme, a taken update moves the state one step toward 11 and stops at 11. A not-taken update moves it one step toward 00 and stops at 00.
- R6: In the majority scheme, an entry shifts in each new outcome and keeps the last three. A lookup predicts taken when at least two of those three outcomes were taken.
- R7: The entry is selected by PC bits [8:2] (the set) and PC bits [10:9] (the entry within the set). All other PC bits have no effect on which entry is read or written.
- R8: When a lookup and an update address the same entry in the same cycle, the lookup returns the prediction from the history before that update. The update is visible to lookups from the next cycle.
- R9: While upd_valid is low, upd_pc and upd_taken change no entry.
- R10: An update changes only the entry its PC selects. Entries that differ in set or way keep their history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | History scheme select (R2 encoding) |
| lk_pc | input | PC_W (32) | Fetch address to predict |
| lk_taken | output | 1 | Prediction for lk_pc, 1 = taken, combinational |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W (32) | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch, 1 = taken |

## Verification
A wrong history value is only visible through lk_taken. It shows up as soon as the affected entry is looked up in a state where the bad bits decide the guess. A counter that steps the wrong way, or fails to saturate, may still predict correctly until one or two more updates push it across the taken boundary. For that reason the sequences drive each scheme through its saturation and threshold points and check every lookup. An update that lands on the wrong entry, or that leaks while upd_valid is low, is caught by looking up both the intended entry and a neighbour that differs only in way, in the very next cycle.

// File: rtl/bht_pkg.sv
package bht_pkg;

    localparam int HIST_W = 3;

    typedef enum logic [1:0] {
        MODE_LAST    = 2'b00,
        MODE_SAT     = 2'b01,
        MODE_VOTE    = 2'b10,
        MODE_SAT_ALT = 2'b11
    } bht_mode_e;

    // Mode 11 is treated as the two-bit counter scheme.
    function automatic logic is_counter_mode(bht_mode_e m);
        return (m == MODE_SAT) || (m == MODE_SAT_ALT);
    endfunction

    function automatic logic [HIST_W-1:0] reset_hist(bht_mode_e m);
        return is_counter_mode(m) ? 3'b001 : 3'b000;
    endfunction

endpackage

// File: rtl/bht_index.sv
module bht_index #(
    parameter int PC_W      = 32,
    parameter int IDX_LSB   = 2,
    parameter int SET_BITS  = 7,
    parameter int WAY_BITS  = 2,
    localparam int IDX_W    = SET_BITS + WAY_BITS
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] entry
);
    localparam int WAY_LSB = IDX_LSB + SET_BITS;

    logic [SET_BITS-1:0] set_sel;
    logic [WAY_BITS-1:0] way_sel;
    logic                unused_pc_bits;

    always_comb begin
        set_sel = pc[IDX_LSB +: SET_BITS];
        way_sel = pc[WAY_LSB +: WAY_BITS];
        entry   = {way_sel, set_sel};
    end

    // Bits outside the index field are deliberately not decoded.
    assign unused_pc_bits = ^pc;

endmodule

// File: rtl/bht_lookup.sv
module bht_lookup
    import bht_pkg::*;
(
    input  bht_mode_e         mode,
    input  logic [HIST_W-1:0] hist,
    output logic              taken
);
    logic vote;

    always_comb begin
        vote = (hist[0] & hist[1]) | (hist[0] & hist[2]) | (hist[1] & hist[2]);
        unique case (mode)
            MODE_LAST:    taken = hist[0];
            MODE_VOTE:    taken = vote;
            MODE_SAT,
            MODE_SAT_ALT: taken = hist[1];
            default:      taken = hist[1];
        endcase
    end

endmodule

// File: rtl/bht_advance.sv
module bht_advance
    import bht_pkg::*;
(
    input  bht_mode_e         mode,
    input  logic [HIST_W-1:0] hist,
    input  logic              outcome,
    output logic [HIST_W-1:0] hist_next
);
    logic [1:0] cnt;
    logic [1:0] cnt_next;

    always_comb begin
        cnt = hist[1:0];
        if (outcome) begin
            cnt_next = (cnt == 2'b11) ? 2'b11 : cnt + 2'b01;
        end else begin
            cnt_next = (cnt == 2'b00) ? 2'b00 : cnt - 2'b01;
        end

        unique case (mode)
            MODE_LAST:    hist_next = {2'b00, outcome};
            MODE_VOTE:    hist_next = {hist[1:0], outcome};
            MODE_SAT,
            MODE_SAT_ALT: hist_next = {1'b0, cnt_next};
            default:      hist_next = {1'b0, cnt_next};
        endcase
    end

endmodule

// File: rtl/bht_multi.sv
module bht_multi
    import bht_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int IDX_LSB  = 2,
    parameter int SET_BITS = 7,
    parameter int WAY_BITS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    localparam int IDX_W   = SET_BITS + WAY_BITS;
    localparam int NUM_ENT = 1 << IDX_W;

    typedef struct packed {
        logic [NUM_ENT-1:0][HIST_W-1:0] hist;
    } bht_state_t;

    bht_state_t        st_d;
    bht_state_t        st_q;
    bht_mode_e         mode_e;
    logic [IDX_W-1:0]  lk_idx;
    logic [IDX_W-1:0]  upd_idx;
    logic [HIST_W-1:0] lk_hist;
    logic [HIST_W-1:0] upd_hist;
    logic [HIST_W-1:0] upd_hist_next;
    logic [HIST_W-1:0] rst_hist;

    assign mode_e = bht_mode_e'(mode);

    bht_index #(
        .PC_W     (PC_W),
        .IDX_LSB  (IDX_LSB),
        .SET_BITS (SET_BITS),
        .WAY_BITS (WAY_BITS)
    ) u_lk_index (
        .pc    (lk_pc),
        .entry (lk_idx)
    );

    bht_index #(
        .PC_W     (PC_W),
        .IDX_LSB  (IDX_LSB),
        .SET_BITS (SET_BITS),
        .WAY_BITS (WAY_BITS)
    ) u_upd_index (
        .pc    (upd_pc),
        .entry (upd_idx)
    );

    // Reads come from the registered table, so a same-cycle write is not seen.
    assign lk_hist  = st_q.hist[lk_idx];
    assign upd_hist = st_q.hist[upd_idx];
    assign rst_hist = reset_hist(mode_e);

    bht_lookup u_lookup (
        .mode  (mode_e),
        .hist  (lk_hist),
        .taken (lk_taken)
    );

    bht_advance u_advance (
        .mode      (mode_e),
        .hist      (upd_hist),
        .outcome   (upd_taken),
        .hist_next (upd_hist_next)
    );

    always_comb begin
        st_d = st_q;
        if (upd_valid) begin
            st_d.hist[upd_idx] = upd_hist_next;
        end
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENT; i++) begin
                st_d.hist[i] = rst_hist;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

endmodule

// File: rtl/bht_multi_chk.sv
module bht_multi_chk #(
    parameter int PC_W     = 32,
    parameter int IDX_LSB  = 2,
    parameter int SET_BITS = 7,
    parameter int WAY_BITS = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      mode,
    input logic [PC_W-1:0] lk_pc,
    input logic            lk_taken,
    input logic            upd_valid,
    input logic [PC_W-1:0] upd_pc,
    input logic            upd_taken
);
    localparam int IDX_W = SET_BITS + WAY_BITS;
    localparam int HI    = IDX_LSB + IDX_W - 1;

    logic [IDX_W-1:0] lk_ent;
    logic [IDX_W-1:0] upd_ent;
    logic             same_ent;
    logic             cnt_mode;
    logic             unused_chk;

    assign lk_ent     = lk_pc[HI:IDX_LSB];
    assign upd_ent    = upd_pc[HI:IDX_LSB];
    assign same_ent   = (lk_ent == upd_ent);
    assign cnt_mode   = mode[0];
    assign unused_chk = ^{lk_pc, upd_pc};

    AST_RESET_PREDICTS_NT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !lk_taken); // R1

    AST_LAST_OUTCOME_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && mode == 2'b00 && same_ent)
        |=> (mode != 2'b00 || lk_ent != $past(upd_ent) || lk_taken == $past(upd_taken))); // R3

    AST_COUNTER_HOLDS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && cnt_mode && mode != 2'b00 && same_ent && upd_taken && lk_taken)
        |=> (mode != $past(mode) || lk_ent != $past(lk_ent) || lk_taken)); // R5

    AST_COUNTER_HOLDS_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && cnt_mode && mode != 2'b00 && same_ent && !upd_taken && !lk_taken)
        |=> (mode != $past(mode) || lk_ent != $past(lk_ent) || !lk_taken)); // R5

    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid
        |=> (mode != $past(mode) || lk_ent != $past(lk_ent) || $stable(lk_taken))); // R9

endmodule

bind bht_multi bht_multi_chk #(
    .PC_W     (PC_W),
    .IDX_LSB  (IDX_LSB),
    .SET_BITS (SET_BITS),
    .WAY_BITS (WAY_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .lk_pc     (lk_pc),
    .lk_taken  (lk_taken),
    .upd_valid (upd_valid),
    .upd_pc    (upd_pc),
    .upd_taken (upd_taken)
);

// File: tb/test_bht_multi.sv
module test_bht_multi;

    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      mode = 2'b01;
    logic [PC_W-1:0] lk_pc = '0;
    logic            lk_taken;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit    exp;
        string req;
    } exp_item_t;

    exp_item_t sb_q[$];
    bit [2:0]  ref_hist [512];
    logic [1:0] ref_mode = 2'b01;

    always #5 clk = ~clk;

    bht_multi i_bht_multi (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .lk_pc     (lk_pc),
        .lk_taken  (lk_taken),
        .upd_valid (upd_valid),
        .upd_pc    (upd_pc),
        .upd_taken (upd_taken)
    );

    // Entry number from R7: way = pc[10:9], set = pc[8:2].
    function automatic int ent(logic [PC_W-1:0] pc);
        return int'({pc[10:9], pc[8:2]});
    endfunction

    // Prediction rules from R3, R4, R6; mode 11 as 01 per R2.
    function automatic bit ref_pred(logic [1:0] m, bit [2:0] h);
        case (m)
            2'b00:   return h[0];
            2'b10:   return (int'(h[0]) + int'(h[1]) + int'(h[2])) >= 2;
            default: return h[1];
        endcase
    endfunction

    // History advance from R3, R5, R6.
    function automatic bit [2:0] ref_next(logic [1:0] m, bit [2:0] h, bit t);
        case (m)
            2'b00:   return {2'b00, t};
            2'b10:   return {h[1:0], t};
            default: begin
                if (t) return (h[1:0] == 2'b11) ? 3'b011 : {1'b0, h[1:0] + 2'b01};
                else   return (h[1:0] == 2'b00) ? 3'b000 : {1'b0, h[1:0] - 2'b01};
            end
        endcase
    endfunction

    // Driver: one cycle of stimulus, optional expected lookup pushed to the scoreboard.
    task automatic step(input logic [PC_W-1:0] lpc, input bit chk, input string req,
                        input bit uv, input logic [PC_W-1:0] upc, input bit ut);
        @(posedge clk);
        #1;
        lk_pc     = lpc;
        upd_valid = uv;
        upd_pc    = upc;
        upd_taken = ut;
        if (chk) begin
            exp_item_t it;
            it.exp = ref_pred(ref_mode, ref_hist[ent(lpc)]);
            it.req = req;
            sb_q.push_back(it);
        end
        if (uv) ref_hist[ent(upc)] = ref_next(ref_mode, ref_hist[ent(upc)], ut);
    endtask

    // Update a PC and look it up in the same cycle.
    task automatic train(input logic [PC_W-1:0] pc, input bit t, input string req);
        step(pc, 1'b1, req, 1'b1, pc, t);
    endtask

    task automatic probe(input logic [PC_W-1:0] pc, input string req);
        step(pc, 1'b1, req, 1'b0, '0, 1'b0);
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(posedge clk);
        #1;
        rst_n     = 1'b0;
        mode      = m;
        upd_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n    = 1'b1;
        ref_mode = m;
        for (int i = 0; i < 512; i++) ref_hist[i] = (m[0]) ? 3'b001 : 3'b000;
    endtask

    // Monitor: compare lookups between clock edges.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                checks++;
                if (lk_taken !== it.exp) begin
                    errors++;
                    $display("FAIL %s: lk_taken=%0b expected %0b at pc=%h",
                             it.req, lk_taken, it.exp, lk_pc);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: run did not end, actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    localparam logic [PC_W-1:0] PA    = 32'h0000_0124;
    localparam logic [PC_W-1:0] PA_AL = 32'hFFFF_F927; // same bits [10:2] as PA
    localparam logic [PC_W-1:0] PB    = 32'h0000_0324; // PA with bit 9 flipped
    localparam logic [PC_W-1:0] PC2   = 32'h0000_0128; // next set

    initial begin
        // Two-bit scheme (mode 01)
        do_reset(2'b01);
        probe(PA, "R1");
        probe(PB, "R1");
        probe(32'h0000_07FC, "R1");
        train(PA, 1'b1, "R8");          // lookup sees 01 (not taken)
        probe(PA, "R5");                // 10 -> taken
        train(PA, 1'b1, "R5");          // ->11
        train(PA, 1'b1, "R5");          // stays 11
        train(PA, 1'b0, "R4");          // ->10
        probe(PA, "R4");                // weakly taken
        train(PA, 1'b0, "R4");          // ->01
        probe(PA, "R4");                // weakly not taken
        train(PA, 1'b0, "R5");          // ->00
        train(PA, 1'b0, "R5");          // stays 00
        train(PA, 1'b1, "R5");          // ->01
        probe(PA, "R5");                // not taken after one step up from floor
        train(PA, 1'b1, "R5");          // ->10
        probe(PA, "R5");

        // Index and independence
        probe(PA_AL, "R7");
        probe(PB, "R10");
        probe(PC2, "R10");
        step(PB, 1'b1, "R7", 1'b1, PA_AL, 1'b1);  // alias writes PA's entry
        probe(PA, "R7");
        probe(PB, "R10");

        // Update with valid low
        step(PA, 1'b1, "R9", 1'b0, PA, 1'b0);
        step(PA, 1'b1, "R9", 1'b0, PA, 1'b0);
        step(PB, 1'b1, "R9", 1'b0, PB, 1'b1);
        step(PB, 1'b1, "R9", 1'b0, PB, 1'b1);
        probe(PA, "R9");

        // Mode 11 follows two-bit rules
        do_reset(2'b11);
        probe(PA, "R2");
        train(PA, 1'b1, "R2");
        probe(PA, "R2");
        train(PA, 1'b0, "R2");
        probe(PA, "R2");

        // Last-outcome scheme
        do_reset(2'b00);
        probe(PA, "R1");
        train(PA, 1'b1, "R3");
        probe(PA, "R3");
        train(PA, 1'b0, "R3");
        probe(PA, "R3");
        train(PA, 1'b1, "R3");
        train(PA, 1'b1, "R3");
        probe(PB, "R10");

        // Majority scheme
        do_reset(2'b10);
        probe(PA, "R1");
        train(PA, 1'b1, "R6");          // 001
        probe(PA, "R6");                // one taken -> not taken
        train(PA, 1'b1, "R6");          // 011
        probe(PA, "R6");                // taken
        train(PA, 1'b0, "R6");          // 110
        probe(PA, "R6");                // taken
        train(PA, 1'b0, "R6");          // 100
        probe(PA, "R6");                // not taken
        train(PA, 1'b1, "R6");          // 001
        train(PA, 1'b0, "R6");          // 010
        probe(PA, "R6");                // not taken
        train(PA, 1'b1, "R6");          // 101
        probe(PA, "R6");                // taken
        probe(PB, "R10");

        step(PA, 1'b0, "", 1'b0, '0, 1'b0);
        @(posedge clk);
        @(posedge clk);
        if (sb_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule